// File: doc/BRIEF.md
# H-Bridge Drive Command Encoder

This block converts a signed drive command into the three logic controls of an H-bridge power stage: a direction line, a brake line and a pulse line. It can encode the command in two ways. In sign/magnitude encoding, the direction line carries the sign and the pulse line carries the absolute value as a duty cycle. In locked anti-phase encoding, the direction line itself is duty-modulated around a 50% midpoint, and the pulse line stays high. A brake request overrides both encodings and shorts the load through both upper drivers.

The command, the mode, the brake request and the period length are captured only at a period boundary, so a pulse is never cut short by a mid-period change. Between the encoder and the pins sits an edge spacer. When an output has to change, the change is queued. Queued changes are released one line at a time, oldest first, and any two released edges are at least `GAP_CYC = ceil(CLK_KHZ/1000)` clocks apart. With `CLK_KHZ` equal to the clock frequency, that gap is at least 1 µs.

The encoder has two states. `ST_WAIT` is the state after reset, when nothing has been sampled yet. The encoder leaves `ST_WAIT` for `ST_RUN` on the first clock, when it takes its first sample, and stays in `ST_RUN`. The spacer also has two states. `ST_IDLE` means it can release an edge. `ST_SPACE` means it is counting out the gap. The spacer moves from `ST_IDLE` to `ST_SPACE` when it releases an edge, and returns to `ST_IDLE` when the count reaches `GAP_CYC-1`. A queued change whose target returns to the current pin level before it is released is dropped.

Top module: `hbridge_cmd_gen`

## Requirements
- R1: While reset is held, BRAKE is 1, PWM is 0 and DIR is 0. This is the bridge state with no driver on.
- R2: In sign/magnitude mode (`mode_i`=0) with no brake request, BRAKE is 0 and DIR is steady. DIR is 1 for a command of zero or more and 0 for a negative command.
- R3: In sign/magnitude mode, PWM is high for `min(|cmd|*P >> (CMD_W-1), P)` clocks in each period of P clocks. A zero command keeps PWM low all the time.
- R4: In locked anti-phase mode (`mode_i`=1) with no brake request, PWM stays 1 and BRAKE stays 0. DIR is high for `((cmd + 2^(CMD_W-1)) * P) >> CMD_W` clocks in each period.
- R5: A brake request drives BRAKE, PWM and DIR all to 1, so both source drivers are on, whatever the mode and the command.
- R6: Command, mode, brake request and period are captured only at a period boundary. A change in the middle of a period leaves the pulse already under way unchanged.
- R7: Two of the outputs never change on the same clock.
- R8: Successive edges on the outputs are at least `GAP_CYC` clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 1 | 0 = sign/magnitude, 1 = locked anti-phase |
| cmd_i | input | CMD_W | Signed two's-complement drive command |
| brake_req_i | input | 1 | Brake request |
| period_i | input | PER_W | PWM period in clocks (values below 2 are treated as 2) |
| dir_o | output | 1 | Direction line to the bridge |
| brake_o | output | 1 | Brake line to the bridge |
| pwm_o | output | 1 | Pulse line to the bridge |

## Verification
The bench sweeps every command in sign/magnitude mode, including the most negative code, which must give a full-period pulse rather than wrapping to zero. A design that wrapped would show PWM stuck low. The bench also sweeps the locked anti-phase commands at both ends of the duty range, where an off-by-one offset would move the DIR high-time by two clocks per period. It changes the command in the middle of a pulse to catch a design that samples the command at any time other than the period boundary, and it enters and leaves braking so that several lines want to move at once, which exposes a spacer that lets two lines move together or releases an edge early. A bridge driver-state model checks that reset gives no driver on and that braking gives both sources on.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic {
        MODE_SM  = 1'b0,
        MODE_LAP = 1'b1
    } hb_mode_e;

    typedef struct packed {
        logic dir;
        logic brake;
        logic pwm;
    } hb_lines_t;

endpackage

// File: rtl/hb_pwm_core.sv
module hb_pwm_core
    import hb_pkg::*;
#(
    parameter int CMD_W = 8,
    parameter int PER_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_i,
    input  logic signed [CMD_W-1:0] cmd_i,
    input  logic                    brake_i,
    input  logic [PER_W-1:0]        per_i,
    output hb_lines_t               tgt_o
);

    localparam int PROD_W = CMD_W + 1 + PER_W;
    localparam logic [CMD_W:0] OFFS = (CMD_W+1)'(1) << (CMD_W - 1);

    typedef enum logic { ST_WAIT, ST_RUN } core_st_e;

    core_st_e         state;
    logic [PER_W-1:0] cnt, per_q, hi_q;
    hb_mode_e         mode_q;
    logic             brk_q, neg_q;

    logic signed [CMD_W:0] ext;
    logic [CMD_W:0]        mag, offs;
    logic [PER_W-1:0]      per_eff, hi_sm, hi_lap, hi_new;
    logic [PROD_W-1:0]     prod_sm, prod_lap;
    logic                  wrap;

    always_comb begin
        ext      = {cmd_i[CMD_W-1], cmd_i};
        mag      = ext[CMD_W] ? $unsigned(-ext) : $unsigned(ext);
        offs     = $unsigned(ext) + OFFS;
        per_eff  = (per_i < PER_W'(2)) ? PER_W'(2) : per_i;
        prod_sm  = PROD_W'(mag) * PROD_W'(per_eff);
        prod_lap = PROD_W'(offs) * PROD_W'(per_eff);
        hi_sm    = PER_W'(prod_sm >> (CMD_W - 1));
        hi_lap   = PER_W'(prod_lap >> CMD_W);
        hi_new   = (mode_i == MODE_LAP) ? hi_lap : hi_sm;
    end

    assign wrap = (state == ST_WAIT) || (cnt == per_q - PER_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_WAIT;
        end else begin
            unique case (state)
                ST_WAIT: state <= ST_RUN;
                ST_RUN:  state <= ST_RUN;
            endcase
        end
    end

    // period counter and boundary capture
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            per_q  <= PER_W'(2);
            hi_q   <= '0;
            mode_q <= MODE_SM;
            brk_q  <= 1'b1;
            neg_q  <= 1'b0;
        end else if (wrap) begin
            cnt    <= '0;
            per_q  <= per_eff;
            hi_q   <= hi_new;
            mode_q <= hb_mode_e'(mode_i);
            brk_q  <= brake_i;
            neg_q  <= cmd_i[CMD_W-1];
        end else begin
            cnt <= cnt + PER_W'(1);
        end
    end

    // output decode
    always_comb begin
        unique case (state)
            ST_WAIT: tgt_o = '{dir: 1'b0, brake: 1'b1, pwm: 1'b0};
            ST_RUN: begin
                if (brk_q)
                    tgt_o = '{dir: 1'b1, brake: 1'b1, pwm: 1'b1};
                else if (mode_q == MODE_LAP)
                    tgt_o = '{dir: (cnt < hi_q), brake: 1'b0, pwm: 1'b1};
                else
                    tgt_o = '{dir: !neg_q, brake: 1'b0, pwm: (cnt < hi_q)};
            end
        endcase
    end

    // R6
    sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && !wrap) |=>
            ($stable(hi_q) && $stable(mode_q) && $stable(brk_q) && $stable(neg_q)));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |-> (cnt < per_q));

endmodule

// File: rtl/hb_edge_guard.sv
module hb_edge_guard #(
    parameter int          NL      = 3,
    parameter int          GAP_CYC = 250,
    parameter logic [NL-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NL-1:0] tgt_i,
    output logic [NL-1:0] out_o
);

    localparam int CW = $clog2(GAP_CYC + 1) + 1;

    typedef enum logic { ST_IDLE, ST_SPACE } grd_st_e;

    grd_st_e       state;
    logic [CW-1:0] gap_cnt;
    logic [NL-1:0] pend, newp, cand, sel;
    logic [NL-1:0] older [NL];
    logic          fire;

    for (genvar gi = 0; gi < NL; gi++) begin : g_line
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int j = 0; j < NL; j++)
                if (j != gi && pend[j] && older[j][gi]) blk = 1'b1;
        end
        assign newp[gi] = !pend[gi] && (tgt_i[gi] != out_o[gi]);
        assign cand[gi] = pend[gi] && !blk && (tgt_i[gi] != out_o[gi]);
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NL; i++)
            if (cand[i] && sel == '0) sel[i] = 1'b1;
    end

    assign fire = (state == ST_IDLE) && (sel != '0);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            gap_cnt <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (fire) begin
                    state   <= ST_SPACE;
                    gap_cnt <= CW'(1);
                end
                ST_SPACE: if (gap_cnt >= CW'(GAP_CYC - 1)) begin
                    state <= ST_IDLE;
                end else begin
                    gap_cnt <= gap_cnt + CW'(1);
                end
            endcase
        end
    end

    // pending queue and outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            out_o <= RST_VAL;
            pend  <= '0;
            for (int i = 0; i < NL; i++) older[i] <= '0;
        end else begin
            if (fire) out_o <= out_o ^ sel;
            for (int i = 0; i < NL; i++) begin
                if (fire && sel[i])
                    pend[i] <= 1'b0;
                else if (pend[i] && tgt_i[i] == out_o[i])
                    pend[i] <= 1'b0;
                else if (newp[i])
                    pend[i] <= 1'b1;
                for (int j = 0; j < NL; j++)
                    older[i][j] <= newp[j] ? pend[i] : (newp[i] ? 1'b0 : older[i][j]);
            end
        end
    end

    // spacing monitor
    logic [NL-1:0] prev_q;
    logic [CW-1:0] since_q;
    logic          chg;
    assign chg = (out_o != prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= RST_VAL;
            since_q <= CW'(GAP_CYC);
        end else begin
            prev_q <= out_o;
            if (chg) since_q <= CW'(1);
            else if (since_q < CW'(GAP_CYC)) since_q <= since_q + CW'(1);
        end
    end

    // R7
    one_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(out_o ^ prev_q) <= 1);

    // R8
    edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
        chg |-> (since_q >= CW'(GAP_CYC)));

endmodule

// File: rtl/hbridge_cmd_gen.sv
module hbridge_cmd_gen
    import hb_pkg::*;
#(
    parameter int CMD_W   = 8,
    parameter int PER_W   = 12,
    parameter int CLK_KHZ = 250000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    mode_i,
    input  logic signed [CMD_W-1:0] cmd_i,
    input  logic                    brake_req_i,
    input  logic [PER_W-1:0]        period_i,
    output logic                    dir_o,
    output logic                    brake_o,
    output logic                    pwm_o
);

    localparam int GAP_RAW = (CLK_KHZ + 999) / 1000;
    localparam int GAP_CYC = (GAP_RAW < 1) ? 1 : GAP_RAW;

    hb_lines_t  tgt;
    logic [2:0] pins;

    hb_pwm_core #(.CMD_W(CMD_W), .PER_W(PER_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .mode_i  (mode_i),
        .cmd_i   (cmd_i),
        .brake_i (brake_req_i),
        .per_i   (period_i),
        .tgt_o   (tgt)
    );

    hb_edge_guard #(.NL(3), .GAP_CYC(GAP_CYC), .RST_VAL(3'b010)) u_guard (
        .clk   (clk),
        .rst   (rst),
        .tgt_i ({tgt.dir, tgt.brake, tgt.pwm}),
        .out_o (pins)
    );

    assign dir_o   = pins[2];
    assign brake_o = pins[1];
    assign pwm_o   = pins[0];

endmodule

// File: tb/hbridge_cmd_gen_bench.sv
module hbridge_cmd_gen_bench;

    localparam int CMD_W = 4;
    localparam int PER_W = 6;
    localparam int P     = 32;
    localparam int GAP   = 3;
    localparam int WIN   = 4 * P;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode = 1'b0;
    logic signed [CMD_W-1:0] cmd = '0;
    logic brk_req = 1'b0;
    logic [PER_W-1:0] per = PER_W'(P);
    logic dir_o, brake_o, pwm_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    hbridge_cmd_gen #(.CMD_W(CMD_W), .PER_W(PER_W), .CLK_KHZ(2500)) u_hbridge_cmd_gen (
        .clk(clk), .rst(rst), .mode_i(mode), .cmd_i(cmd), .brake_req_i(brk_req),
        .period_i(per), .dir_o(dir_o), .brake_o(brake_o), .pwm_o(pwm_o)
    );

    // bridge driver model: {src1, snk1, src2, snk2}
    function automatic logic [3:0] drivers(input logic d, input logic b, input logic p);
        if (!b) return p ? (d ? 4'b1001 : 4'b0110) : 4'b1010;
        return p ? (d ? 4'b1010 : 4'b0101) : 4'b0000;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // edge spacing monitor (R7, R8)
    logic [2:0] prev_s = 3'b010;
    int since = 1000;
    always @(negedge clk) begin
        if (rst) begin
            prev_s <= 3'b010;
            since  <= 1000;
        end else begin
            logic [2:0] now;
            now = {dir_o, brake_o, pwm_o};
            if (now != prev_s) begin
                chk($countones(now ^ prev_s) <= 1, "R7 simultaneous edges",
                    $countones(now ^ prev_s), 1);
                chk(since >= GAP, "R8 edge gap", since, GAP);
                since <= 1;
            end else if (since < 1000) begin
                since <= since + 1;
            end
            prev_s <= now;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    int hd, hb, hp;
    task automatic measure();
        hd = 0; hb = 0; hp = 0;
        for (int k = 0; k < WIN; k++) begin
            @(negedge clk);
            hd += int'(dir_o); hb += int'(brake_o); hp += int'(pwm_o);
        end
    endtask

    task automatic settle();
        for (int k = 0; k < 6 * P; k++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        for (int k = 0; k < 5; k++) @(negedge clk);
        chk(brake_o == 1'b1, "R1 brake in reset", int'(brake_o), 1);
        chk(pwm_o == 1'b0, "R1 pwm in reset", int'(pwm_o), 0);
        chk(dir_o == 1'b0, "R1 dir in reset", int'(dir_o), 0);
        chk(drivers(dir_o, brake_o, pwm_o) == 4'b0000, "R1 no driver",
            int'(drivers(dir_o, brake_o, pwm_o)), 0);
        rst = 1'b0;

        // R2, R3: sign/magnitude sweep
        mode = 1'b0;
        for (int c = -8; c <= 7; c++) begin
            int mg, exp_hi;
            cmd = CMD_W'(c);
            settle();
            measure();
            mg = (c < 0) ? -c : c;
            exp_hi = (mg * P) >> (CMD_W - 1);
            if (exp_hi > P) exp_hi = P;
            chk(hp == 4 * exp_hi, "R3 pwm high time", hp, 4 * exp_hi);
            chk(hd == ((c >= 0) ? WIN : 0), "R2 dir sign", hd, (c >= 0) ? WIN : 0);
            chk(hb == 0, "R2 brake low", hb, 0);
        end

        // R4: locked anti-phase sweep
        mode = 1'b1;
        for (int c = -8; c <= 6; c++) begin
            int exp_hi;
            if (c == -7) continue;
            cmd = CMD_W'(c);
            settle();
            measure();
            exp_hi = ((c + 8) * P) >> CMD_W;
            chk(hd == 4 * exp_hi, "R4 dir high time", hd, 4 * exp_hi);
            chk(hp == WIN, "R4 pwm held high", hp, WIN);
            chk(hb == 0, "R4 brake low", hb, 0);
        end

        // R5: brake request, both modes
        for (int m = 0; m < 2; m++) begin
            mode = m[0];
            cmd = CMD_W'(-3);
            brk_req = 1'b1;
            settle();
            measure();
            chk(hd == WIN && hb == WIN && hp == WIN, "R5 brake lines", hd + hb + hp, 3 * WIN);
            chk(drivers(dir_o, brake_o, pwm_o) == 4'b1010, "R5 both sources",
                int'(drivers(dir_o, brake_o, pwm_o)), 10);
            brk_req = 1'b0;
        end

        // R6: mid-pulse command change
        mode = 1'b0;
        cmd = CMD_W'(4);
        settle();
        begin
            int w1, w2, guard_n;
            guard_n = 0;
            while (!(pwm_o == 1'b0) && guard_n < 4 * P) begin @(negedge clk); guard_n++; end
            while (pwm_o == 1'b0 && guard_n < 8 * P) begin @(negedge clk); guard_n++; end
            w1 = 0;
            while (pwm_o == 1'b1 && w1 < 2 * P) begin
                w1++;
                if (w1 == 3) cmd = CMD_W'(6);
                @(negedge clk);
            end
            chk(w1 == 16, "R6 pulse kept old width", w1, 16);
            while (pwm_o == 1'b0 && guard_n < 12 * P) begin @(negedge clk); guard_n++; end
            w2 = 0;
            while (pwm_o == 1'b1 && w2 < 2 * P) begin w2++; @(negedge clk); end
            chk(w2 == 24, "R6 next pulse new width", w2, 24);
        end

        // R7, R8: brake to reverse drive, many lines move together
        brk_req = 1'b1;
        settle();
        brk_req = 1'b0;
        cmd = CMD_W'(-5);
        settle();
        measure();
        chk(hd == 0 && hb == 0 && hp == 4 * 20, "R8 after brake release", hp, 80);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule